// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers characters from an asynchronous serial line. The line is first synchronised to the local clock. A falling edge opens a candidate start bit, and the block confirms it half a bit later. After that the data bits, an optional parity bit and the first stop bit are each sampled at mid-bit, counted on a 16x oversampling tick enable.

The character format comes from the same configuration inputs that drive the matching transmitter:
- word length, 5 to 8 bits;
- parity mode: none, odd, even, or a parity bit forced to a fixed value;
- one or two stop bits.

Every completed character produces a one-clock strobe. The strobe carries the received byte, with the unused upper bits cleared, and flags for a parity mismatch, a bad stop bit and a line break.

Top module: `uart_frame_rx`

## Requirements
- R1: Word-length code `wlen_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data arrives least-significant bit first, and `data_o` bits at and above the word length read 0.
- R2: A falling edge starts a start bit only if the line is still low at its mid-point, 8 ticks later. Otherwise the edge is dropped and no character is reported.
- R3: With `par_en_i` = 0, the stop bit follows the last data bit directly and `parity_err_o` stays 0.
- R4: With `par_en_i` = 1 and `sticky_i` = 0, `even_sel_i` = 0 expects an odd count of ones across data plus parity, and `even_sel_i` = 1 expects an even count. A mismatch raises `parity_err_o`.
- R5: With `par_en_i` = 1 and `sticky_i` = 1, the parity bit must be 1 when `even_sel_i` = 0 and 0 when `even_sel_i` = 1. Any other value raises `parity_err_o`.
- R6: Only the first stop bit is checked. If it is sampled as 0, `frame_err_o` is raised.
- R7: A frame whose start, data, parity (if enabled) and first stop bit are all 0 raises `break_o` together with `frame_err_o`. No new character is then taken until the line has returned high.
- R8: `valid_o` is high for exactly one clock per character. `data_o` and all three error flags are presented in that same clock, and the flags are 0 in every other clock.
- R9: With `two_stop_i` = 1, falling edges are ignored for 16 ticks after the first stop sample (8 ticks for 5-bit characters). With `two_stop_i` = 0, the receiver is ready again right after the first stop sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| rxd_i | input | 1 | Serial input, idle high |
| wlen_i | input | 2 | Word-length code (5 + code bits) |
| par_en_i | input | 1 | Parity bit present |
| even_sel_i | input | 1 | Even select, or forced-bit polarity when sticky |
| sticky_i | input | 1 | Forced parity mode |
| two_stop_i | input | 1 | Two stop bits (1.5 for 5-bit characters) |
| data_o | output | 8 | Received character, zero-filled above word length |
| valid_o | output | 1 | One-clock character strobe |
| parity_err_o | output | 1 | Parity mismatch, with strobe |
| frame_err_o | output | 1 | First stop bit sampled low, with strobe |
| break_o | output | 1 | All-zero frame, with strobe |

## Verification
The assertions assume two things. First, the format inputs stay constant from the start edge until the strobe. Second, a frame's stop bit is high or low for the whole bit time. The zero-fill check in particular depends on the word length matching the character just received. The stimulus changes the format only while the line idles between frames. It holds the tick enable high, so a bit time is exactly 16 clocks, and it changes the line only on bit boundaries, apart from the deliberate short glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD,
    RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign q_o    = pipe_q[STAGES-1];
  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              sticky_i,
  input  logic              even_sel_i,
  output logic              exp_o
);
  // data_i is zero above the word length, so a full-width XOR is exact
  always_comb begin
    if (sticky_i) exp_o = ~even_sel_i;
    else          exp_o = even_sel_i ? (^data_i) : ~(^data_i);
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              even_sel_i,
  input  logic              sticky_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              break_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q, ones_q;
  logic              rxd_s, fall;
  logic              exp_par;
  logic [IDX_W-1:0]  idx_last;
  logic [CNT_W-1:0]  hold_last;
  logic              cnt_end, half_end;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s),
    .fall_o (fall)
  );

  uart_rx_parity #(.DATA_W(DATA_W)) u_par (
    .data_i     (shreg_q),
    .sticky_i   (sticky_i),
    .even_sel_i (even_sel_i),
    .exp_o      (exp_par)
  );

  assign idx_last  = IDX_W'(4) + IDX_W'(wlen_i);
  assign hold_last = (wlen_i == 2'd0) ? HALF_LAST : BIT_LAST;
  assign cnt_end   = tick_i && (cnt_q == BIT_LAST);
  assign half_end  = tick_i && (cnt_q == HALF_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      idx_q        <= '0;
      shreg_q      <= '0;
      par_q        <= 1'b0;
      ones_q       <= 1'b0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
      break_o      <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
      break_o      <= 1'b0;
      if (tick_i && state_q inside {RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD})
        cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          if (fall) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (half_end) begin
            cnt_q <= '0;
            if (rxd_s) begin
              state_q <= RX_IDLE;  // glitch
            end else begin
              state_q <= RX_DATA;
              idx_q   <= '0;
              shreg_q <= '0;
              par_q   <= 1'b0;
              ones_q  <= 1'b0;
            end
          end
        end
        RX_DATA: begin
          if (cnt_end) begin
            cnt_q          <= '0;
            shreg_q[idx_q] <= rxd_s;
            ones_q         <= ones_q | rxd_s;
            if (idx_q == idx_last) state_q <= par_en_i ? RX_PAR : RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_end) begin
            cnt_q   <= '0;
            par_q   <= rxd_s;
            ones_q  <= ones_q | rxd_s;
            state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (cnt_end) begin
            cnt_q        <= '0;
            valid_o      <= 1'b1;
            data_o       <= shreg_q;
            parity_err_o <= par_en_i && (par_q != exp_par);
            frame_err_o  <= ~rxd_s;
            break_o      <= ~rxd_s & ~ones_q;
            if (~rxd_s & ~ones_q) state_q <= RX_WAIT_HI;
            else if (two_stop_i)  state_q <= RX_HOLD;
            else                  state_q <= RX_IDLE;
          end
        end
        RX_HOLD: begin
          if (tick_i && cnt_q == hold_last) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
          end
        end
        RX_WAIT_HI: begin
          if (rxd_s) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // Assertions
  logic [3:0] nbits;
  assign nbits = 4'd5 + {2'b00, wlen_i};

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_flags_with_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_o || frame_err_o || break_o) |-> valid_o);

  assert_break_framing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> frame_err_o);

  assert_zero_fill_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> nbits) == '0));

  assert_no_parity_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !parity_err_o);

  assert_break_waits_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_WAIT_HI && !rxd_s) |=> (state_q == RX_WAIT_HI));
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int BIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic       pen = 1'b0, es = 1'b0, sp = 1'b0, ts = 1'b0;
  logic [7:0] data;
  logic       valid, perr, ferr, brk;

  int tests = 0, fails = 0, v_cnt = 0;
  logic [7:0] got_d;
  logic got_pe, got_fe, got_brk;
  bit done = 0;

  always #2 clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .wlen_i(wlen), .par_en_i(pen), .even_sel_i(es), .sticky_i(sp),
    .two_stop_i(ts), .data_o(data), .valid_o(valid),
    .parity_err_o(perr), .frame_err_o(ferr), .break_o(brk)
  );

  always @(negedge clk) begin
    if (valid) begin
      v_cnt++;
      got_d = data; got_pe = perr; got_fe = ferr; got_brk = brk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  // mode: 0 none, 1 odd, 2 even, 3 forced 1, 4 forced 0
  task automatic frame(input logic [7:0] d, input logic [1:0] wl, input int mode,
                       input logic two, input logic flip, input logic bad_stop);
    int nb, v0;
    logic [7:0] dm;
    logic pbit, exp_brk;
    nb = 5 + int'(wl);
    dm = d & 8'((1 << nb) - 1);
    wlen = wl; ts = two;
    pen = (mode != 0);
    sp  = (mode >= 3);
    es  = (mode == 2) || (mode == 4);
    if (mode == 1)      pbit = ~^dm;
    else if (mode == 2) pbit = ^dm;
    else                pbit = (mode == 3);
    pbit = pbit ^ flip;
    exp_brk = bad_stop && (dm == 0) && !(pen && pbit);
    v0 = v_cnt;
    @(negedge clk);
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(dm[i]);
    if (pen) bit_out(pbit);
    bit_out(!bad_stop);
    if (two) bit_out(1'b1);
    bit_out(1'b1);
    bit_out(1'b1);
    chk("R8 one strobe per character", 32'(v_cnt - v0), 32'd1);
    chk("R1 data word length and zero fill", {24'd0, got_d}, {24'd0, dm});
    chk(mode >= 3 ? "R5 forced parity check" : (pen ? "R4 odd/even parity check" : "R3 no parity"),
        {31'd0, got_pe}, {31'd0, pen && flip});
    chk("R6 framing error", {31'd0, got_fe}, {31'd0, bad_stop});
    chk("R7 break flag", {31'd0, got_brk}, {31'd0, exp_brk});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v0;
    repeat (4) @(negedge clk);
    chk("R8 reset valid", {31'd0, valid}, 32'd0);
    chk("R8 reset flags", {29'd0, perr, ferr, brk}, 32'd0);
    chk("R1 reset data", {24'd0, data}, 32'd0);
    rst_n = 1'b1;
    repeat (BIT) @(negedge clk);

    // Sweep over word lengths, parity modes and data patterns
    for (int wl = 0; wl < 4; wl++)
      for (int m = 0; m < 5; m++)
        for (int k = 0; k < 16; k++)
          frame(8'((k * 37 + wl * 11 + m * 5 + (k << 4)) & 255), 2'(wl), m,
                k[1], (m != 0) && k[0], (k % 5) == 3);

    // R2: short glitch is rejected
    wlen = 2'd3; pen = 1'b0; ts = 1'b0;
    v0 = v_cnt;
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (4 * BIT) @(negedge clk);
    chk("R2 glitch rejected", 32'(v_cnt - v0), 32'd0);
    frame(8'hC3, 2'd3, 0, 1'b0, 1'b0, 1'b0);

    // R7: break then line held low
    v0 = v_cnt;
    for (int i = 0; i < 13; i++) bit_out(1'b0);
    chk("R7 break strobe count", 32'(v_cnt - v0), 32'd1);
    chk("R7 break flag set", {31'd0, got_brk}, 32'd1);
    chk("R7 break implies framing", {31'd0, got_fe}, 32'd1);
    chk("R7 break data zero", {24'd0, got_d}, 32'd0);
    bit_out(1'b1); bit_out(1'b1);
    frame(8'h5A, 2'd3, 2, 1'b0, 1'b0, 1'b0);

    // R9: start edge in the second stop bit time
    for (int two = 0; two < 2; two++) begin
      wlen = 2'd3; pen = 1'b0; ts = 1'(two);
      v0 = v_cnt;
      bit_out(1'b0);
      for (int i = 0; i < 8; i++) bit_out(i[0]);
      bit_out(1'b1);
      bit_out(1'b0);
      for (int i = 0; i < 12; i++) bit_out(1'b1);
      chk(two ? "R9 two stops ignore early edge" : "R9 one stop accepts next frame",
          32'(v_cnt - v0), two ? 32'd1 : 32'd2);
      if (two == 0) chk("R9 back-to-back data", {24'd0, got_d}, 32'hFF);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule